// File: doc/BRIEF.md
# Non-Posted Credit Availability Gate

A requester that sends non-posted requests into a link core can stall its own posted traffic. This happens when the core holds a non-posted request for lack of header credit, data credit or a free tag. This gate decides, before a request is handed to the core, whether the core can accept it at once. The core reports three 4-bit counts: non-posted header credit, non-posted data credit and free tags. Each count reads 0 for none, and the code 15 means fifteen or more. These counts reach the user two clock cycles late, so they do not yet reflect requests issued in the two most recent cycles.

The gate keeps a short record of what the user issued in each of the last two cycles. For every count, it subtracts that consumption from the reported value and clamps the result at zero. It then compares the adjusted counts against the pending requests. Every request takes one header credit and one tag, and the user supplies the request's data-credit need. When straddling is enabled, a second, later request can go out in the same cycle. That second request is permitted only if the counts also cover the first request's consumption. A reported 15 is used as exactly 15, which keeps the decision safe.

Top module: `np_credit_gate`

## Requirements
- R1: In the first cycle after reset is released, each adjusted count equals its reported count. Issue activity during reset is not recorded.
- R2: In every cycle, `adj_hdr` is max(0, `rpt_hdr` − H1 − H2). H1 is the number of requests counted as issued in the previous cycle, and H2 is the number counted two cycles back.
- R3: Each counted request consumes exactly one tag. `adj_tag` is max(0, `rpt_tag` − H1 − H2), using the same per-cycle request counts as the header.
- R4: `adj_dat` is max(0, `rpt_dat` − D1 − D2). D1 and D2 are the sums of the data needs of the requests counted in the previous cycle and two cycles back. A lane's need is the 4-bit field `req_need[4k+3:4k]`.
- R5: An adjusted count never goes below zero. When the consumption exceeds the report, the output is 0.
- R6: `permit[0]` is high exactly when all of the following hold: `req_valid[0]` is high, `adj_hdr` ≥ 1, `adj_tag` ≥ 1, and `adj_dat` ≥ lane 0's need.
- R7: With `straddle_en` high, `permit[1]` is high exactly when all of the following hold: `permit[0]` is high, `req_valid[1]` is high, `adj_hdr` ≥ 2, `adj_tag` ≥ 2, and `adj_dat` ≥ the sum of the needs of lane 0 and lane 1.
- R8: With `straddle_en` low, `permit[1]` stays low, and `issue[1]` is not counted as consumption in any adjusted count.
- R9: `permit[1]` is never high while `permit[0]` is low.
- R10: A request's consumption stops being subtracted three cycles after its issue cycle. After two cycles with no issue, every adjusted count equals its report.

Lane 0 is always the earlier request. A request is counted as issued in a cycle when its `issue` bit is high at the rising clock edge. Lane 1 is counted only while `straddle_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| straddle_en | input | 1 | Enables the second request lane |
| rpt_hdr | input | 4 | Reported non-posted header credit, saturating at 15 |
| rpt_dat | input | 4 | Reported non-posted data credit, saturating at 15 |
| rpt_tag | input | 4 | Reported free tags, saturating at 15 |
| req_valid | input | 2 | A request is pending on lane k |
| req_need | input | 8 | Data-credit need per lane, 4 bits each, lane 0 in the low bits |
| issue | input | 2 | The request on lane k is transferred this cycle |
| permit | output | 2 | The request on lane k may be issued without blocking |
| adj_hdr | output | 4 | Lag-corrected header credit |
| adj_dat | output | 4 | Lag-corrected data credit |
| adj_tag | output | 4 | Lag-corrected tag count |

## Verification
The consumption history is the only state in the block, and the adjusted counts expose it directly. A slot that shifts wrongly, misses a straddled lane or holds a value too long makes an adjusted count differ from the bench's figure in the very next cycle. That error stays visible for up to two cycles, until the faulty entry ages out. A fault in the permit chain appears in the same cycle as the stimulus, so the bench sweeps exact-fit and one-short data needs, clamps at zero, and a disabled straddle lane.

// File: rtl/np_gate_pkg.sv
package np_gate_pkg;

   // Bits needed to hold any value from 0 to n inclusive.
   function automatic int bits_for(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Largest value a need field of w bits can carry.
   function automatic int need_max(input int w);
      return (1 << w) - 1;
   endfunction

endpackage

// File: rtl/np_consume_tally.sv
module np_consume_tally
   import np_gate_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int NEED_W = 4,
   parameter int HC_W   = bits_for(LANES),
   parameter int DC_W   = bits_for(LANES * need_max(NEED_W))
)
(
   input  logic                      straddle_en,
   input  logic [LANES-1:0]          issue,
   input  logic [LANES*NEED_W-1:0]   req_need,
   output logic [HC_W-1:0]           cons_hdr,
   output logic [DC_W-1:0]           cons_dat
);

   logic [LANES-1:0] lane_live;

   // Lane 0 always counts; later lanes only while straddling.
   for (genvar k = 0; k < LANES; k++) begin : g_live
      if (k == 0) begin : g_first
         assign lane_live[k] = issue[k];
      end else begin : g_later
         assign lane_live[k] = issue[k] & straddle_en;
      end
   end

   always_comb begin
      cons_hdr = '0;
      cons_dat = '0;
      for (int k = 0; k < LANES; k++) begin
         if (lane_live[k]) begin
            cons_hdr = cons_hdr + HC_W'(1);
            cons_dat = cons_dat + DC_W'(req_need[k*NEED_W +: NEED_W]);
         end
      end
   end

endmodule

// File: rtl/np_lag_history.sv
module np_lag_history
   import np_gate_pkg::*;
#(
   parameter int LAG    = 2,
   parameter int HC_W   = 2,
   parameter int DC_W   = 5,
   parameter int HSUM_W = 3,
   parameter int DSUM_W = 6
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HC_W-1:0]   cons_hdr,
   input  logic [DC_W-1:0]   cons_dat,
   output logic [HSUM_W-1:0] sum_hdr,
   output logic [DSUM_W-1:0] sum_dat
);

   logic [HC_W-1:0] hist_hdr [LAG];
   logic [DC_W-1:0] hist_dat [LAG];

   // Slot 0 is the previous cycle; slot LAG-1 is the oldest still unreported.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LAG; i++) begin
            hist_hdr[i] <= '0;
            hist_dat[i] <= '0;
         end
      end else begin
         hist_hdr[0] <= cons_hdr;
         hist_dat[0] <= cons_dat;
         for (int i = 1; i < LAG; i++) begin
            hist_hdr[i] <= hist_hdr[i-1];
            hist_dat[i] <= hist_dat[i-1];
         end
      end
   end

   always_comb begin
      sum_hdr = '0;
      sum_dat = '0;
      for (int i = 0; i < LAG; i++) begin
         sum_hdr = sum_hdr + HSUM_W'(hist_hdr[i]);
         sum_dat = sum_dat + DSUM_W'(hist_dat[i]);
      end
   end

endmodule

// File: rtl/np_avail_adjust.sv
module np_avail_adjust
   import np_gate_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int SUB_W = 3
)
(
   input  logic [CNT_W-1:0] rpt,
   input  logic [SUB_W-1:0] sub,
   output logic [CNT_W-1:0] adj
);

   // One spare bit acts as the sign of the difference.
   localparam int DW = max_of(CNT_W, SUB_W) + 1;

   logic [DW-1:0] diff;

   assign diff = DW'(rpt) - DW'(sub);
   assign adj  = diff[DW-1] ? '0 : diff[CNT_W-1:0];

endmodule

// File: rtl/np_permit_logic.sv
module np_permit_logic
   import np_gate_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int CNT_W  = 4,
   parameter int NEED_W = 4
)
(
   input  logic                    straddle_en,
   input  logic [LANES-1:0]        req_valid,
   input  logic [LANES*NEED_W-1:0] req_need,
   input  logic [CNT_W-1:0]        adj_hdr,
   input  logic [CNT_W-1:0]        adj_dat,
   input  logic [CNT_W-1:0]        adj_tag,
   output logic [LANES-1:0]        permit
);

   localparam int CUM_W = bits_for(LANES * need_max(NEED_W));
   localparam int CMP_W = max_of(max_of(CNT_W, CUM_W), bits_for(LANES)) + 1;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [CMP_W-1:0] SLOTS = CMP_W'(k + 1);

      logic [CUM_W-1:0] own;
      logic [CUM_W-1:0] cum;
      logic             live;
      logic             prior_ok;
      logic             hdr_ok;
      logic             tag_ok;
      logic             dat_ok;
      logic             ok;

      assign own = CUM_W'(req_need[k*NEED_W +: NEED_W]);

      if (k == 0) begin : g_head
         assign cum      = own;
         assign live     = 1'b1;
         assign prior_ok = 1'b1;
      end else begin : g_tail
         assign cum      = g_lane[k-1].cum + own;
         assign live     = straddle_en;
         assign prior_ok = g_lane[k-1].ok;
      end

      // Lane k must fit together with every earlier lane in the same cycle.
      assign hdr_ok = CMP_W'(adj_hdr) >= SLOTS;
      assign tag_ok = CMP_W'(adj_tag) >= SLOTS;
      assign dat_ok = CMP_W'(adj_dat) >= CMP_W'(cum);
      assign ok     = live & req_valid[k] & prior_ok & hdr_ok & tag_ok & dat_ok;

      assign permit[k] = ok;
   end

endmodule

// File: rtl/np_credit_gate.sv
module np_credit_gate
   import np_gate_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int NEED_W = 4,
   parameter int LANES  = 2,
   parameter int LAG    = 2
)
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    straddle_en,
   input  logic [CNT_W-1:0]        rpt_hdr,
   input  logic [CNT_W-1:0]        rpt_dat,
   input  logic [CNT_W-1:0]        rpt_tag,
   input  logic [LANES-1:0]        req_valid,
   input  logic [LANES*NEED_W-1:0] req_need,
   input  logic [LANES-1:0]        issue,
   output logic [LANES-1:0]        permit,
   output logic [CNT_W-1:0]        adj_hdr,
   output logic [CNT_W-1:0]        adj_dat,
   output logic [CNT_W-1:0]        adj_tag
);

   localparam int HC_W   = bits_for(LANES);
   localparam int DC_W   = bits_for(LANES * need_max(NEED_W));
   localparam int HSUM_W = bits_for(LAG * LANES);
   localparam int DSUM_W = bits_for(LAG * LANES * need_max(NEED_W));

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("np_credit_gate: CNT_W out of range");
   end
   if (NEED_W < 1 || NEED_W > 8) begin : g_bad_need
      $error("np_credit_gate: NEED_W out of range");
   end
   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("np_credit_gate: LANES out of range");
   end
   if (LAG < 1 || LAG > 8) begin : g_bad_lag
      $error("np_credit_gate: LAG out of range");
   end

   logic [HC_W-1:0]   cons_hdr;
   logic [DC_W-1:0]   cons_dat;
   logic [HSUM_W-1:0] sum_hdr;
   logic [DSUM_W-1:0] sum_dat;

   np_consume_tally #(
      .LANES  (LANES),
      .NEED_W (NEED_W),
      .HC_W   (HC_W),
      .DC_W   (DC_W)
   ) u_tally (
      .straddle_en (straddle_en),
      .issue       (issue),
      .req_need    (req_need),
      .cons_hdr    (cons_hdr),
      .cons_dat    (cons_dat)
   );

   np_lag_history #(
      .LAG    (LAG),
      .HC_W   (HC_W),
      .DC_W   (DC_W),
      .HSUM_W (HSUM_W),
      .DSUM_W (DSUM_W)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .cons_hdr (cons_hdr),
      .cons_dat (cons_dat),
      .sum_hdr  (sum_hdr),
      .sum_dat  (sum_dat)
   );

   // Tags follow the header count: one of each per request.
   np_avail_adjust #(.CNT_W(CNT_W), .SUB_W(HSUM_W)) u_adj_hdr (
      .rpt (rpt_hdr),
      .sub (sum_hdr),
      .adj (adj_hdr)
   );

   np_avail_adjust #(.CNT_W(CNT_W), .SUB_W(DSUM_W)) u_adj_dat (
      .rpt (rpt_dat),
      .sub (sum_dat),
      .adj (adj_dat)
   );

   np_avail_adjust #(.CNT_W(CNT_W), .SUB_W(HSUM_W)) u_adj_tag (
      .rpt (rpt_tag),
      .sub (sum_hdr),
      .adj (adj_tag)
   );

   np_permit_logic #(
      .LANES  (LANES),
      .CNT_W  (CNT_W),
      .NEED_W (NEED_W)
   ) u_permit (
      .straddle_en (straddle_en),
      .req_valid   (req_valid),
      .req_need    (req_need),
      .adj_hdr     (adj_hdr),
      .adj_dat     (adj_dat),
      .adj_tag     (adj_tag),
      .permit      (permit)
   );

endmodule

// File: rtl/np_credit_gate_chk.sv
module np_credit_gate_chk
   import np_gate_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int NEED_W = 4,
   parameter int LANES  = 2,
   parameter int LAG    = 2
)
(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    straddle_en,
   input logic [CNT_W-1:0]        rpt_hdr,
   input logic [CNT_W-1:0]        rpt_dat,
   input logic [CNT_W-1:0]        rpt_tag,
   input logic [LANES-1:0]        req_valid,
   input logic [LANES*NEED_W-1:0] req_need,
   input logic [LANES-1:0]        issue,
   input logic [LANES-1:0]        permit,
   input logic [CNT_W-1:0]        adj_hdr,
   input logic [CNT_W-1:0]        adj_dat,
   input logic [CNT_W-1:0]        adj_tag
);

   localparam int QW = bits_for(LAG);

   // Cycles since any issue bit was last high, saturating at LAG.
   logic [QW-1:0] quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                quiet <= QW'(LAG);
      else if (|issue)           quiet <= '0;
      else if (quiet < QW'(LAG)) quiet <= quiet + 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (adj_hdr == rpt_hdr && adj_dat == rpt_dat && adj_tag == rpt_tag));

   assert_hdr_tag_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_hdr == rpt_tag) |-> (adj_hdr == adj_tag));

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_hdr <= rpt_hdr) && (adj_dat <= rpt_dat) && (adj_tag <= rpt_tag));

   assert_head_permit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      permit[0] |-> (req_valid[0] && adj_hdr != '0 && adj_tag != '0 &&
                     int'(adj_dat) >= int'(req_need[NEED_W-1:0])));

   assert_lag_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet >= QW'(LAG)) |-> (adj_hdr == rpt_hdr && adj_dat == rpt_dat && adj_tag == rpt_tag));

   if (LANES >= 2) begin : g_pair
      assert_second_fit_R7: assert property (@(posedge clk) disable iff (!rst_n)
         permit[1] |-> (req_valid[1] && int'(adj_hdr) >= 2 && int'(adj_tag) >= 2 &&
                        int'(adj_dat) >= int'(req_need[NEED_W-1:0]) + int'(req_need[2*NEED_W-1:NEED_W])));

      assert_single_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !straddle_en |-> !permit[1]);

      assert_lane_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
         permit[1] |-> permit[0]);
   end

endmodule

bind np_credit_gate np_credit_gate_chk #(
   .CNT_W  (CNT_W),
   .NEED_W (NEED_W),
   .LANES  (LANES),
   .LAG    (LAG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .straddle_en (straddle_en),
   .rpt_hdr     (rpt_hdr),
   .rpt_dat     (rpt_dat),
   .rpt_tag     (rpt_tag),
   .req_valid   (req_valid),
   .req_need    (req_need),
   .issue       (issue),
   .permit      (permit),
   .adj_hdr     (adj_hdr),
   .adj_dat     (adj_dat),
   .adj_tag     (adj_tag)
);

// File: tb/sim_np_credit_gate.sv
`timescale 1ns/1ps
module sim_np_credit_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       straddle_en = 1'b0;
   logic [3:0] rpt_hdr = '0;
   logic [3:0] rpt_dat = '0;
   logic [3:0] rpt_tag = '0;
   logic [1:0] req_valid = '0;
   logic [7:0] req_need = '0;
   logic [1:0] issue = '0;
   logic [1:0] permit;
   logic [3:0] adj_hdr;
   logic [3:0] adj_dat;
   logic [3:0] adj_tag;

   int checks = 0;
   int fails  = 0;

   // Bench model of the consumption in the last two cycles.
   int mh1 = 0, mh2 = 0, md1 = 0, md2 = 0;

   always #2.5 clk = ~clk;

   np_credit_gate u0 (
      .clk (clk), .rst_n (rst_n), .straddle_en (straddle_en),
      .rpt_hdr (rpt_hdr), .rpt_dat (rpt_dat), .rpt_tag (rpt_tag),
      .req_valid (req_valid), .req_need (req_need), .issue (issue),
      .permit (permit), .adj_hdr (adj_hdr), .adj_dat (adj_dat), .adj_tag (adj_tag)
   );

   function automatic int floor0(input int v);
      return (v < 0) ? 0 : v;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one cycle from a negedge, check the combinational outputs, record consumption.
   task automatic step(input string lbl, input bit s, input int rh, input int rd, input int rt,
                       input bit [1:0] rv, input int n0, input int n1, input bit [1:0] iss);
      int eh, ed, et, ch, cd;
      bit p0, p1;
      straddle_en = s;
      rpt_hdr = 4'(rh); rpt_dat = 4'(rd); rpt_tag = 4'(rt);
      req_valid = rv;
      req_need = {4'(n1), 4'(n0)};
      issue = iss;
      #1;
      eh = floor0(rh - mh1 - mh2);
      ed = floor0(rd - md1 - md2);
      et = floor0(rt - mh1 - mh2);
      p0 = rv[0] && eh >= 1 && et >= 1 && ed >= n0;
      p1 = s && rv[1] && p0 && eh >= 2 && et >= 2 && ed >= n0 + n1;
      chk((lbl != "") ? lbl : "R2", int'(adj_hdr), eh);
      chk((lbl != "") ? lbl : "R4", int'(adj_dat), ed);
      chk((lbl != "") ? lbl : "R3", int'(adj_tag), et);
      chk("R6", int'(permit[0]), int'(p0));
      chk(s ? "R7" : "R8", int'(permit[1]), int'(p1));
      chk("R9", int'(permit[1] && !permit[0]), 0);
      ch = int'(iss[0]) + ((s && iss[1]) ? 1 : 0);
      cd = (iss[0] ? n0 : 0) + ((s && iss[1]) ? n1 : 0);
      mh2 = mh1; mh1 = ch;
      md2 = md1; md1 = cd;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // Heavy issue activity while in reset must not be recorded.
      issue = 2'b11; req_need = 8'hFF; straddle_en = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step("R1", 1, 7, 3, 5, 2'b00, 0, 0, 2'b00);

      // One request with one data credit, then a straddled pair with none.
      step("", 1, 7, 3, 5, 2'b01, 1, 0, 2'b01);
      step("", 1, 7, 3, 5, 2'b11, 0, 0, 2'b11);
      step("", 1, 7, 3, 5, 2'b11, 1, 1, 2'b00);   // adjusted 4/2/2

      // Clamp at zero.
      step("", 1, 3, 2, 2, 2'b11, 2, 2, 2'b11);
      step("", 1, 3, 2, 2, 2'b11, 2, 2, 2'b11);
      step("R5", 1, 1, 0, 1, 2'b01, 0, 0, 2'b00);
      step("R5", 1, 2, 3, 1, 2'b01, 0, 0, 2'b00);
      // Third quiet cycle: older issues have aged out.
      step("R10", 1, 9, 6, 4, 2'b00, 0, 0, 2'b00);

      // Exact fit and one-short for the straddled second lane.
      step("", 1, 15, 5, 15, 2'b11, 2, 3, 2'b00);
      step("", 1, 15, 5, 15, 2'b11, 2, 4, 2'b00);
      step("", 1, 2, 5, 1, 2'b11, 0, 0, 2'b00);
      step("", 1, 2, 5, 2, 2'b11, 0, 0, 2'b00);

      // Straddle disabled: lane 1 neither permitted nor counted.
      step("", 0, 15, 15, 15, 2'b11, 0, 9, 2'b11);
      step("R8", 0, 15, 15, 15, 2'b11, 0, 9, 2'b10);
      step("R8", 0, 15, 15, 15, 2'b11, 1, 1, 2'b00);
      chk("R8", int'(adj_dat), 15);

      for (int i = 0; i < 800; i++) begin
         int n0, n1;
         bit s;
         n0 = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 3);
         n1 = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 3);
         s  = ($urandom % 5 != 0);
         step("", s, int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
              2'($urandom), n0, n1, 2'($urandom));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule